// File: doc/BRIEF.md
# 1-Wire Bit and Search-Triplet Slot Engine

This block produces the time slots of a 1-Wire master on an open-drain line. A single-bit operation runs one slot: it writes the bit the host supplies, and then reads the line back. A triplet operation runs the three slots of one search step in hardware. The first two slots are read slots. The third is a write slot whose value the engine chooses from the two bits it sampled and the host's preferred branch. The engine pulls the line low through a pull-down enable. It senses the line through a synchroniser and samples it at a fixed count inside each slot.

The line is modelled as a wired-AND of the engine's pull-down and an external level that carries the slaves' drive. All slot timing is given in clock cycles through parameters. The results are held in four flags:

- the first sampled bit;
- the second sampled bit of a triplet;
- the branch direction that was written;
- a no-responder indication.

These flags stay valid until a later operation updates them. A busy output covers the whole operation.

Top module: `owm_slot_engine`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `line_pd_o`, `sbr_o`, `tsb_o`, `dir_o` and `nodev_o` are all 0.
- R2: A start strobe seen at a clock edge while idle sets `busy_o` from the next cycle. `busy_o` stays set for exactly SLOT_CYC cycles for a single-bit operation (`triplet_i`=0) and 3*SLOT_CYC cycles for a triplet (`triplet_i`=1).
- R3: Each slot begins with `line_pd_o`=1 in its first busy cycle. The pull-down lasts LOW1_CYC cycles for a slot that writes 1 or reads, and LOW0_CYC cycles for a slot that writes 0. It stays 0 for the rest of the slot.
- R4: After a single-bit operation, `sbr_o` equals the line level sampled in its slot. Writing 0 always gives `sbr_o`=0. Writing 1 gives the slaves' level.
- R5: A single-bit operation leaves `tsb_o`, `dir_o` and `nodev_o` unchanged.
- R6: After a triplet, `sbr_o` holds the level sampled in the first slot and `tsb_o` the level sampled in the second slot.
- R7: When the two sampled triplet bits differ, the third slot writes the first bit and `dir_o` equals that bit.
- R8: When both sampled bits are 0, the third slot writes `dir_pref_i` as captured with the accepted start strobe, and `dir_o` equals it.
- R9: When both sampled bits are 1, the third slot writes 1 and `dir_o`=1 and `nodev_o`=1. Any other triplet outcome clears `nodev_o`.
- R10: A start strobe that arrives while `busy_o`=1 is ignored. The running operation's slot count, pulse lengths and results do not change, and changing `triplet_i`, `bit_i` or `dir_pref_i` at that time has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for one operation |
| triplet_i | input | 1 | 1 selects a search triplet, 0 a single-bit slot |
| bit_i | input | 1 | Bit written by a single-bit operation |
| dir_pref_i | input | 1 | Branch taken by a triplet when both sampled bits are 0 |
| line_i | input | 1 | Level driven by the slaves (1 = released) |
| line_pd_o | output | 1 | Pull-down enable; 1 holds the line low |
| busy_o | output | 1 | Operation in progress |
| sbr_o | output | 1 | First sampled bit |
| tsb_o | output | 1 | Second sampled bit of the last triplet |
| dir_o | output | 1 | Branch written by the last triplet |
| nodev_o | output | 1 | Last triplet read 1 in both slots |

## Verification
`busy_o` and `line_pd_o` are registered. Both reflect the slot counter one cycle after each clock edge. Starting at the cycle after the accepted strobe, the reference model keeps its own slot counter, and the bench compares both outputs with it at every falling edge. The flags change during an operation, at the sample count of slot one or two and at the start of slot three. Because of that, they are compared with the model's values only in cycles where the model is idle, from the cycle after `busy_o` falls onward. The slave model changes `line_i` only at slot starts and holds it for the whole slot, so the sample point itself, two synchroniser cycles after the level is set, never decides a result.

// File: rtl/owm_pkg.sv
package owm_pkg;

  localparam int unsigned TRIP_SLOTS = 3;
  localparam int unsigned SLOT_IDX_W = $clog2(TRIP_SLOTS);

  typedef struct packed {
    logic sbr;
    logic tsb;
    logic dir;
    logic nodev;
  } owm_flags_t;

  // branch choice for the write slot of a search step
  function automatic logic pick_branch(input logic b0, input logic b1,
                                       input logic pref);
    if (b0 != b1)  return b0;
    else if (!b0)  return pref;
    else           return 1'b1;
  endfunction

endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b1;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/owm_slot_timer.sv
module owm_slot_timer #(
  parameter int unsigned LOW1_CYC   = 750,
  parameter int unsigned LOW0_CYC   = 7500,
  parameter int unsigned SAMPLE_CYC = 1875,
  parameter int unsigned SLOT_CYC   = 8750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic wbit_i,
  output logic pd_o,
  output logic sample_o,
  output logic last_o
);

  localparam int unsigned CNT_W = $clog2(SLOT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_SAMP = CNT_W'(SAMPLE_CYC);
  localparam logic [CNT_W-1:0] LEN_ONE  = CNT_W'(LOW1_CYC);
  localparam logic [CNT_W-1:0] LEN_ZERO = CNT_W'(LOW0_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             wbit_q, wbit_d;
  logic             pd_q, pd_d;
  logic [CNT_W-1:0] low_len;

  always_comb begin
    cnt_d  = cnt_q;
    act_d  = act_q;
    wbit_d = wbit_q;
    if (go_i) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      wbit_d = wbit_i;
    end else if (act_q) begin
      if (cnt_q == CNT_LAST) act_d = 1'b0;
      else                   cnt_d = cnt_q + 1'b1;
    end
    low_len = wbit_d ? LEN_ONE : LEN_ZERO;
    pd_d    = act_d && (cnt_d < low_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      wbit_q <= 1'b1;
      pd_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      wbit_q <= wbit_d;
      pd_q   <= pd_d;
    end
  end

  assign pd_o     = pd_q;
  assign sample_o = act_q && (cnt_q == CNT_SAMP);
  assign last_o   = act_q && (cnt_q == CNT_LAST);

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cnt_q >= LEN_ZERO) |-> !pd_q);

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !pd_q);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

endmodule

// File: rtl/owm_seq.sv
module owm_seq
  import owm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       triplet_i,
  input  logic       bit_i,
  input  logic       pref_i,
  input  logic       line_s_i,
  input  logic       sample_i,
  input  logic       last_i,
  output logic       go_o,
  output logic       wbit_o,
  output logic       busy_o,
  output owm_flags_t flags_o
);

  localparam logic [SLOT_IDX_W-1:0] SLOT_FINAL = SLOT_IDX_W'(TRIP_SLOTS - 1);

  logic                  busy_q, busy_d;
  logic                  trip_q, trip_d;
  logic                  wbit1_q, wbit1_d;
  logic                  pref_q, pref_d;
  logic [SLOT_IDX_W-1:0] slot_q, slot_d;
  owm_flags_t            flags_q, flags_d;

  logic accept, more, branch;

  assign accept = start_i && !busy_q;
  assign more   = trip_q && (slot_q != SLOT_FINAL);
  assign branch = pick_branch(flags_q.sbr, flags_q.tsb, pref_q);

  always_comb begin
    go_o   = accept || (last_i && more);
    wbit_o = 1'b1;
    if (accept)                       wbit_o = triplet_i | bit_i;
    else if (slot_q == SLOT_FINAL - 1) wbit_o = branch;
  end

  always_comb begin
    busy_d  = busy_q;
    trip_d  = trip_q;
    wbit1_d = wbit1_q;
    pref_d  = pref_q;
    slot_d  = slot_q;
    flags_d = flags_q;
    if (accept) begin
      busy_d  = 1'b1;
      trip_d  = triplet_i;
      wbit1_d = bit_i;
      pref_d  = pref_i;
      slot_d  = '0;
    end else if (busy_q) begin
      if (sample_i) begin
        if (slot_q == '0)                flags_d.sbr = line_s_i;
        else if (trip_q && slot_q == 1)  flags_d.tsb = line_s_i;
      end
      if (last_i) begin
        if (more) begin
          slot_d = slot_q + 1'b1;
          if (slot_q == SLOT_FINAL - 1) begin
            flags_d.dir   = branch;
            flags_d.nodev = flags_q.sbr & flags_q.tsb;
          end
        end else begin
          busy_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      trip_q  <= 1'b0;
      wbit1_q <= 1'b0;
      pref_q  <= 1'b0;
      slot_q  <= '0;
      flags_q <= '0;
    end else begin
      busy_q  <= busy_d;
      trip_q  <= trip_d;
      wbit1_q <= wbit1_d;
      pref_q  <= pref_d;
      slot_q  <= slot_d;
      flags_q <= flags_d;
    end
  end

  assign busy_o  = busy_q;
  assign flags_o = flags_q;

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> ($stable(trip_q) && $stable(pref_q) && $stable(wbit1_q)));

  // R5
  single_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !trip_q) |=> ($stable(flags_q.tsb) && $stable(flags_q.dir) && $stable(flags_q.nodev)));

  // R9
  nodev_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.nodev |-> flags_q.dir);

  // R4
  zero_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !trip_q && !wbit1_q) |-> !flags_q.sbr);

endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int unsigned LOW1_CYC    = 750,
  parameter int unsigned LOW0_CYC    = 7500,
  parameter int unsigned SAMPLE_CYC  = 1875,
  parameter int unsigned SLOT_CYC    = 8750,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic triplet_i,
  input  logic bit_i,
  input  logic dir_pref_i,
  input  logic line_i,
  output logic line_pd_o,
  output logic busy_o,
  output logic sbr_o,
  output logic tsb_o,
  output logic dir_o,
  output logic nodev_o
);

  logic       pd, line_lvl, line_s;
  logic       go, wbit, sample, last;
  owm_flags_t flags;

  assign line_lvl = line_i & ~pd;

  owm_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_lvl),
    .q_o   (line_s)
  );

  owm_slot_timer #(
    .LOW1_CYC   (LOW1_CYC),
    .LOW0_CYC   (LOW0_CYC),
    .SAMPLE_CYC (SAMPLE_CYC),
    .SLOT_CYC   (SLOT_CYC)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (go),
    .wbit_i   (wbit),
    .pd_o     (pd),
    .sample_o (sample),
    .last_o   (last)
  );

  owm_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .triplet_i (triplet_i),
    .bit_i     (bit_i),
    .pref_i    (dir_pref_i),
    .line_s_i  (line_s),
    .sample_i  (sample),
    .last_i    (last),
    .go_o      (go),
    .wbit_o    (wbit),
    .busy_o    (busy_o),
    .flags_o   (flags)
  );

  assign line_pd_o = pd;
  assign sbr_o     = flags.sbr;
  assign tsb_o     = flags.tsb;
  assign dir_o     = flags.dir;
  assign nodev_o   = flags.nodev;

  // R2
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |-> busy_o);

endmodule

// File: tb/owm_slot_engine_tb_top.sv
`timescale 1ns/1ps
module owm_slot_engine_tb_top;

  localparam int L1 = 6;
  localparam int L0 = 60;
  localparam int SP = 15;
  localparam int SL = 70;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, triplet_i, bit_i, dir_pref_i, line_i;
  logic line_pd_o, busy_o, sbr_o, tsb_o, dir_o, nodev_o;

  always #4 clk = ~clk;

  owm_slot_engine #(
    .LOW1_CYC(L1), .LOW0_CYC(L0), .SAMPLE_CYC(SP), .SLOT_CYC(SL), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .triplet_i(triplet_i),
    .bit_i(bit_i), .dir_pref_i(dir_pref_i), .line_i(line_i),
    .line_pd_o(line_pd_o), .busy_o(busy_o), .sbr_o(sbr_o), .tsb_o(tsb_o),
    .dir_o(dir_o), .nodev_o(nodev_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;

  // planned slave responses for the next operation
  bit s_r0, s_r1;

  // reference model state
  int m_busy, m_slot, m_cnt, m_n;
  bit m_trip, m_bit, m_pref;
  bit m_resp[3];
  bit m_wr[3];
  bit e_sbr, e_tsb, e_dir, e_nod;

  function automatic bit choose(bit a, bit b, bit p);
    if (a != b) return a;
    if (a == 1'b0) return p;
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_slot = 0; m_cnt = 0; m_n = 1;
      e_sbr = 0; e_tsb = 0; e_dir = 0; e_nod = 0;
      line_i <= 1'b1;
    end else if (m_busy != 0) begin
      if (m_cnt == SL - 1) begin
        if (m_slot == m_n - 1) begin
          m_busy = 0;
          line_i <= 1'b1;
          if (m_trip) begin
            e_sbr = m_resp[0];
            e_tsb = m_resp[1];
            e_dir = m_wr[2];
            e_nod = m_resp[0] & m_resp[1];
          end else begin
            e_sbr = m_bit & m_resp[0];
          end
        end else begin
          m_slot++;
          m_cnt = 0;
          line_i <= m_resp[m_slot];
        end
      end else begin
        m_cnt++;
      end
    end else if (start_i) begin
      m_busy = 1; m_slot = 0; m_cnt = 0;
      m_trip = triplet_i; m_bit = bit_i; m_pref = dir_pref_i;
      m_n = triplet_i ? 3 : 1;
      m_resp[0] = s_r0;
      m_resp[1] = triplet_i ? s_r1 : 1'b1;
      m_resp[2] = 1'b1;
      m_wr[0] = triplet_i ? 1'b1 : bit_i;
      m_wr[1] = 1'b1;
      m_wr[2] = choose(s_r0, s_r1, dir_pref_i);
      line_i <= s_r0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_pd;
      exp_pd = (m_busy != 0) && (m_cnt < (m_wr[m_slot] ? L1 : L0));
      chk(busy_o == (m_busy != 0), "R2 R10 busy", busy_o, m_busy);
      chk(line_pd_o == exp_pd, "R3 R7 R8 R9 pull-down", line_pd_o, exp_pd);
      if (m_busy == 0) begin
        chk(sbr_o == e_sbr, "R4 R6 sbr", sbr_o, e_sbr);
        chk(tsb_o == e_tsb, "R5 R6 tsb", tsb_o, e_tsb);
        chk(dir_o == e_dir, "R5 R7 R8 dir", dir_o, e_dir);
        chk(nodev_o == e_nod, "R5 R9 nodev", nodev_o, e_nod);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2: actual busy %0d expected 0", busy_o);
      finish_run();
    end
  end

  task automatic pulse_start(bit t, bit b, bit p);
    @(negedge clk);
    triplet_i = t; bit_i = b; dir_pref_i = p; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_op(bit t, bit b, bit p, bit r0, bit r1);
    s_r0 = r0; s_r1 = r1;
    pulse_start(t, b, p);
    wait_idle();
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; triplet_i = 1'b0; bit_i = 1'b0;
    dir_pref_i = 1'b0; s_r0 = 1'b1; s_r1 = 1'b1;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk({busy_o, line_pd_o, sbr_o, tsb_o, dir_o, nodev_o} == 6'b0, "R1 reset", 
        {busy_o, line_pd_o, sbr_o, tsb_o, dir_o, nodev_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 after release
    chk({busy_o, line_pd_o, sbr_o, tsb_o, dir_o, nodev_o} == 6'b0, "R1 after release",
        {busy_o, line_pd_o, sbr_o, tsb_o, dir_o, nodev_o}, 0);

    // R4 single-bit slots
    run_op(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    run_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    run_op(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    // R6 R7 differing bits
    run_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    run_op(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    // R8 both zero, both preferences
    run_op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R9 no responder
    run_op(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    // R5 single bits after a triplet keep tsb/dir/nodev
    run_op(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);

    // R10 strobes while busy with different inputs
    s_r0 = 1'b0; s_r1 = 1'b0;
    pulse_start(1'b1, 1'b0, 1'b1);
    repeat (30) @(negedge clk);
    pulse_start(1'b0, 1'b0, 1'b0);
    repeat (SL) @(negedge clk);
    pulse_start(1'b0, 1'b1, 1'b0);
    wait_idle();
    chk(dir_o == 1'b1, "R10 R8 latched preference", dir_o, 1);

    finish_run();
  end

endmodule